// File: doc/BRIEF.md
# Scrambled ROM Word Fetch Path

This block answers read-only word fetches from an on-chip ROM whose addresses and contents are both scrambled. A requester raises a request strobe with a logical word address. The address goes through a keyed, bijective substitution-permutation network to produce the physical row, and the physical row is read into a register. In the same cycle a keyed mixing function of the logical address is computed and registered as a 39-bit keystream. On the following cycle the raw 39-bit word passes through a data substitution-permutation network and is XORed with the keystream. The result is 32 data bits and 7 integrity bits, returned with a valid strobe.

All keys, the nonce and the content seed are compile-time parameters. The ROM image itself is derived at elaboration time from a parameterised plaintext rule, run backwards through the keystream and the inverse networks. The block therefore needs no external content file, and a test environment can predict every returned word from the logical address alone. There is no write path, no byte enable and no runtime key. The integrity bits are passed through and are not checked here.

Top module: `scrom_fetch`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rsp_valid_o` is low.
- R2: `rsp_valid_o` is high in exactly those cycles that follow a clock edge at which `req_i` was sampled high. No response appears without a request.
- R3: For logical address a, the returned `rsp_data_o` equals `PLAIN_SEED ^ (a * 32'h0100_0193)`, where a is zero-extended to 32 bits and the product is taken modulo 2^32.
- R4: With a valid response, `rsp_chk_o` equals `rsp_data_o[6:0] ^ rsp_data_o[31:25]`. These are the 7 stored integrity bits, passed through unchanged.
- R5: Requests on consecutive cycles are all served. Each response appears one cycle after its own request, in request order, with no gap.
- R6: After a cycle without a request, `rsp_data_o` and `rsp_chk_o` keep the values of the last response.
- R7: The address network is a permutation of the whole address range. Every logical address from 0 to 2^AW-1 returns its own distinct word, as given by R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Fetch request strobe |
| addr_i | input | AW | Logical word address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_data_o | output | 32 | Descrambled data bits |
| rsp_chk_o | output | 7 | Descrambled integrity bits |

## Verification
The hardest case to reach from the ports is a full stream of requests on consecutive cycles. In that stream the array register, the keystream register and the valid flag each carry a new address on every edge, so any mismatch between the two parallel paths would pair a word with the wrong keystream. The bench reaches it by sweeping every logical address back to back with no idle cycle, so that each response is checked in the same cycle in which the next request is presented. Idle gaps between isolated requests then show that the output registers hold their last value.

// File: rtl/scrom_pkg.sv
package scrom_pkg;

    localparam int unsigned WORD_W      = 39;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned CHK_W       = 7;
    localparam int unsigned MAX_AW      = 16;
    localparam int unsigned ADDR_ROUNDS = 2;
    localparam int unsigned DATA_ROUNDS = 3;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MAX_AW-1:0] aidx_t;

    typedef struct packed { logic  vld; } ctl_t;
    typedef struct packed { word_t raw; } arr_t;
    typedef struct packed { word_t ks;  } kst_t;

    function automatic aidx_t amask(input int unsigned aw);
        logic [31:0] full;
        full = (32'd1 << aw) - 32'd1;
        return full[MAX_AW-1:0];
    endfunction

    // keyed bijection on aw-bit addresses: xor, add, rotate, xorshift
    function automatic aidx_t addr_fwd(input aidx_t a, input logic [63:0] key,
                                       input int unsigned aw);
        aidx_t m, x, rk, rc;
        m = amask(aw);
        x = a & m;
        for (int r = 0; r < int'(ADDR_ROUNDS); r++) begin
            rk = aidx_t'(key >> (r * 16));
            rc = aidx_t'(key >> (r * 16 + 8));
            x  = (x ^ rk) & m;
            x  = (x + rc) & m;
            x  = ((x << 1) | (x >> (aw - 1))) & m;
            x  = x ^ (x >> 1);
        end
        return x;
    endfunction

    function automatic aidx_t addr_inv(input aidx_t p, input logic [63:0] key,
                                       input int unsigned aw);
        aidx_t m, x, y, rk, rc;
        m = amask(aw);
        x = p & m;
        for (int r = int'(ADDR_ROUNDS) - 1; r >= 0; r--) begin
            rk = aidx_t'(key >> (r * 16));
            rc = aidx_t'(key >> (r * 16 + 8));
            y  = x;
            for (int i = 0; i < int'(MAX_AW); i++) y = x ^ (y >> 1);
            x  = y;
            x  = ((x >> 1) | ((x & aidx_t'(1)) << (aw - 1))) & m;
            x  = (x - rc) & m;
            x  = (x ^ rk) & m;
        end
        return x;
    endfunction

    // keyed bijection on 39-bit words
    function automatic word_t data_fwd(input word_t w, input logic [63:0] key);
        word_t x, rk, rc;
        x = w;
        for (int r = 0; r < int'(DATA_ROUNDS); r++) begin
            rk = word_t'({key, key} >> (r * 13));
            rc = word_t'(key >> (r * 7));
            x  = x ^ rk;
            x  = x + rc;
            x  = (x << 7) | (x >> (WORD_W - 7));
            x  = x ^ (x >> 5);
        end
        return x;
    endfunction

    function automatic word_t data_inv(input word_t w, input logic [63:0] key);
        word_t x, y, rk, rc;
        x = w;
        for (int r = int'(DATA_ROUNDS) - 1; r >= 0; r--) begin
            rk = word_t'({key, key} >> (r * 13));
            rc = word_t'(key >> (r * 7));
            y  = x;
            for (int i = 0; i < int'(WORD_W); i++) y = x ^ (y >> 5);
            x  = y;
            x  = (x >> 7) | (x << (WORD_W - 7));
            x  = x - rc;
            x  = x ^ rk;
        end
        return x;
    endfunction

    // keyed mixing function standing in for a lightweight cipher
    function automatic word_t ks_fn(input aidx_t a, input logic [63:0] key,
                                    input logic [63:0] nonce);
        logic [63:0] v;
        v = key ^ ({48'd0, a} * 64'h9E37_79B9_7F4A_7C15);
        v = v ^ (v >> 29);
        v = (v * 64'hBF58_476D_1CE4_E5B9) ^ nonce;
        v = v ^ (v >> 32);
        return v[WORD_W-1:0];
    endfunction

    function automatic word_t plain_fn(input aidx_t a, input logic [31:0] seed);
        logic [31:0] d;
        d = seed ^ ({16'd0, a} * 32'h0100_0193);
        return {d[6:0] ^ d[31:25], d};
    endfunction

    // stored word at physical row p
    function automatic word_t rom_image(input aidx_t p, input int unsigned aw,
                                        input logic [63:0] akey, input logic [63:0] dkey,
                                        input logic [63:0] kkey, input logic [63:0] nonce,
                                        input logic [31:0] seed);
        aidx_t a;
        a = addr_inv(p, akey, aw);
        return data_inv(plain_fn(a, seed) ^ ks_fn(a, kkey, nonce), dkey);
    endfunction

endpackage

// File: rtl/scrom_addr_map.sv
module scrom_addr_map
    import scrom_pkg::*;
#(
    parameter int unsigned AW       = 6,
    parameter logic [63:0] ADDR_KEY = 64'h3C91_D0A7_5E24_B86F
) (
    input  logic [AW-1:0] laddr_i,
    output logic [AW-1:0] paddr_o
);
    aidx_t mapped;

    always_comb begin
        mapped  = addr_fwd(aidx_t'(laddr_i), ADDR_KEY, AW);
        paddr_o = mapped[AW-1:0];
    end
endmodule

// File: rtl/scrom_array.sv
module scrom_array
    import scrom_pkg::*;
#(
    parameter int unsigned AW         = 6,
    parameter logic [63:0] ADDR_KEY   = 64'h3C91_D0A7_5E24_B86F,
    parameter logic [63:0] DATA_KEY   = 64'h81F4_2B6C_E953_0DA7,
    parameter logic [63:0] KS_KEY     = 64'h5B0E_C7A2_19D4_F863,
    parameter logic [63:0] NONCE      = 64'hA7D3_4E19_60BC_F285,
    parameter logic [31:0] PLAIN_SEED = 32'hC3A5_1E0F
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [AW-1:0] paddr_i,
    output word_t         raw_o
);
    localparam int unsigned DEPTH = 1 << AW;

    word_t tbl [DEPTH];
    arr_t  st_d, st_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        assign tbl[g] = rom_image(aidx_t'(g), AW, ADDR_KEY, DATA_KEY,
                                  KS_KEY, NONCE, PLAIN_SEED);
    end

    always_comb begin
        st_d = st_q;
        if (en_i) st_d.raw = tbl[paddr_i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign raw_o = st_q.raw;

    assert_array_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(raw_o));
endmodule

// File: rtl/scrom_keystream.sv
module scrom_keystream
    import scrom_pkg::*;
#(
    parameter int unsigned AW     = 6,
    parameter logic [63:0] KS_KEY = 64'h5B0E_C7A2_19D4_F863,
    parameter logic [63:0] NONCE  = 64'hA7D3_4E19_60BC_F285
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [AW-1:0] laddr_i,
    output word_t         ks_o
);
    kst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) st_d.ks = ks_fn(aidx_t'(laddr_i), KS_KEY, NONCE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ks_o = st_q.ks;

    assert_ks_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(ks_o));
endmodule

// File: rtl/scrom_data_unscr.sv
module scrom_data_unscr
    import scrom_pkg::*;
#(
    parameter logic [63:0] DATA_KEY = 64'h81F4_2B6C_E953_0DA7
) (
    input  word_t raw_i,
    input  word_t ks_i,
    output word_t word_o
);
    always_comb word_o = data_fwd(raw_i, DATA_KEY) ^ ks_i;
endmodule

// File: rtl/scrom_fetch.sv
module scrom_fetch
    import scrom_pkg::*;
#(
    parameter int unsigned AW         = 6,
    parameter logic [63:0] ADDR_KEY   = 64'h3C91_D0A7_5E24_B86F,
    parameter logic [63:0] DATA_KEY   = 64'h81F4_2B6C_E953_0DA7,
    parameter logic [63:0] KS_KEY     = 64'h5B0E_C7A2_19D4_F863,
    parameter logic [63:0] NONCE      = 64'hA7D3_4E19_60BC_F285,
    parameter logic [31:0] PLAIN_SEED = 32'hC3A5_1E0F
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    output logic          rsp_valid_o,
    output logic [31:0]   rsp_data_o,
    output logic [6:0]    rsp_chk_o
);
    logic [AW-1:0] paddr;
    word_t         raw, ks, word;
    ctl_t          st_d, st_q;

    scrom_addr_map #(.AW(AW), .ADDR_KEY(ADDR_KEY)) u_map (
        .laddr_i (addr_i),
        .paddr_o (paddr)
    );

    scrom_array #(
        .AW(AW), .ADDR_KEY(ADDR_KEY), .DATA_KEY(DATA_KEY),
        .KS_KEY(KS_KEY), .NONCE(NONCE), .PLAIN_SEED(PLAIN_SEED)
    ) u_array (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (req_i),
        .paddr_i (paddr),
        .raw_o   (raw)
    );

    scrom_keystream #(.AW(AW), .KS_KEY(KS_KEY), .NONCE(NONCE)) u_ks (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (req_i),
        .laddr_i (addr_i),
        .ks_o    (ks)
    );

    scrom_data_unscr #(.DATA_KEY(DATA_KEY)) u_unscr (
        .raw_i  (raw),
        .ks_i   (ks),
        .word_o (word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rsp_valid_o = st_q.vld;
    assign rsp_data_o  = word[DATA_W-1:0];
    assign rsp_chk_o   = word[WORD_W-1:DATA_W];

    // the row selected must map back to the logical address
    assert_addr_bijective_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |-> (addr_inv(aidx_t'(paddr), ADDR_KEY, AW) == aidx_t'(addr_i)));

    assert_valid_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> rsp_valid_o);

    assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !rsp_valid_o);

    assert_chk_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (rsp_chk_o == (rsp_data_o[6:0] ^ rsp_data_o[31:25])));

    assert_hold_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> $stable({rsp_chk_o, rsp_data_o}));
endmodule

// File: tb/scrom_fetch_test.sv
module scrom_fetch_test;
    localparam int          AW    = 6;
    localparam int          DEPTH = 1 << AW;
    localparam logic [31:0] SEED  = 32'h7E1D_93C4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;
    logic [6:0]    rsp_chk;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    scrom_fetch #(
        .AW(AW),
        .ADDR_KEY(64'h1F2E_3D4C_5B6A_7988),
        .DATA_KEY(64'h0123_4567_89AB_CDEF),
        .KS_KEY(64'hFEDC_BA98_7654_3210),
        .NONCE(64'h55AA_33CC_0FF0_9669),
        .PLAIN_SEED(SEED)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_chk_o(rsp_chk)
    );

    function automatic logic [31:0] exp_data(input int a);
        return SEED ^ (32'(a) * 32'h0100_0193);
    endfunction

    function automatic logic [6:0] exp_chk(input logic [31:0] d);
        return d[6:0] ^ d[31:25];
    endfunction

    task automatic check_word(input string tag, input int a);
        logic [31:0] ed;
        logic [6:0]  ec;
        ed = exp_data(a);
        ec = exp_chk(ed);
        n_tests++;
        if (rsp_valid !== 1'b1 || rsp_data !== ed || rsp_chk !== ec) begin
            n_fail++;
            $display("FAIL %s addr=%0d: valid=%b data=%h chk=%h, expected valid=1 data=%h chk=%h",
                     tag, a, rsp_valid, rsp_data, rsp_chk, ed, ec);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // R1: quiet during and right after reset
    task automatic t_reset();
        @(negedge clk);
        check_bit("R1 valid in reset", rsp_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 valid after release", rsp_valid, 1'b0);
    endtask

    // R2 R3 R4: isolated requests with idle gaps
    task automatic t_single(input int a);
        req = 1'b1; addr = AW'(a);
        @(negedge clk);
        req = 1'b0; addr = '0;
        check_word("R3/R4 single", a);
        @(negedge clk);
        check_bit("R2 no valid without request", rsp_valid, 1'b0);
    endtask

    // R5: back-to-back run
    task automatic t_burst(input int start, input int len, input int step);
        int prev;
        prev = -1;
        for (int i = 0; i < len; i++) begin
            req = 1'b1; addr = AW'(start + i * step);
            @(negedge clk);
            check_word("R5 burst", (start + i * step) % DEPTH);
        end
        req = 1'b0;
        @(negedge clk);
        check_bit("R2 valid drops after burst", rsp_valid, 1'b0);
    endtask

    // R6: output holds across idle cycles, address changes ignored
    task automatic t_hold(input int a);
        logic [31:0] ed;
        req = 1'b1; addr = AW'(a);
        @(negedge clk);
        req = 1'b0;
        ed = exp_data(a);
        for (int i = 0; i < 4; i++) begin
            addr = AW'(a + 7 + i);
            @(negedge clk);
            n_tests++;
            if (rsp_data !== ed || rsp_chk !== exp_chk(ed)) begin
                n_fail++;
                $display("FAIL R6 hold: data=%h chk=%h, expected data=%h chk=%h",
                         rsp_data, rsp_chk, ed, exp_chk(ed));
            end
        end
    endtask

    // R7: full sweep, each word its own and distinct
    task automatic t_sweep();
        logic [31:0] seen [DEPTH];
        int dup;
        dup = 0;
        for (int a = 0; a < DEPTH; a++) begin
            req = 1'b1; addr = AW'(a);
            @(negedge clk);
            check_word("R7 sweep", a);
            seen[a] = rsp_data;
        end
        req = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            for (int j = i + 1; j < DEPTH; j++)
                if (seen[i] == seen[j]) dup++;
        n_tests++;
        if (dup != 0) begin
            n_fail++;
            $display("FAIL R7 distinct words: duplicates=%0d expected=0", dup);
        end
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_single(0);
        t_single(DEPTH - 1);
        t_single(21);
        t_single(42);
        t_burst(5, 6, 1);
        t_burst(60, 8, 9);
        t_hold(13);
        t_sweep();
        t_single(1);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule